// File: doc/BRIEF.md
# Nibble-serial response packet transmitter

This block sits on the I/O side of a narrow point-to-point link and returns acknowledgements to the requester. The return path is a 4-bit data bus plus one frame strobe. A response is handed over through a valid/ready handshake. It carries an opcode, a 2-bit size code, an error flag, an 8-bit transaction ID and up to 64 bits of read data. The block turns it into a packet of bytes and sends each byte as two nibbles.

A packet starts with two header bytes. When the opcode asks for data, the header is followed by 1, 2, 4 or 8 read-data bytes, chosen by the size code and sent least significant byte first. An error response that carries data keeps its full length, but its data bytes are zero. The frame strobe marks only the very first nibble of a packet. Between packets the bus rests at zero with the strobe low. Decoding requests and matching IDs are handled elsewhere.

Top module: `bl_rsp_tx`

## Requirements
- R1: While reset is held and right after it is released, `tx_nib` is 0, `tx_frame` is 0 and `rsp_ready` is 1.
- R2: Header byte 0 has the following layout: bit 7 is 0, bit 6 is the error flag, bits 5:4 are the size code, bit 3 is 1 and bits 2:0 are the opcode. It is sent as the first two nibbles, bits 3:0 first and then bits 7:4.
- R3: Header byte 1 is the transaction ID. It is sent as nibbles 2 and 3, low half first.
- R4: `tx_frame` is 1 on the first nibble of a packet and 0 on every other cycle.
- R5: Opcode 1 selects a response with data. After the header it sends 1, 2, 4 or 8 data bytes for size codes 0, 1, 2 and 3. The bytes go least significant first, each byte low nibble first. This gives packets of 6, 8, 12 or 20 nibbles.
- R6: Any opcode other than 1 sends only the 4 header nibbles. The data input has no effect on such a packet.
- R7: A response with opcode 1 and the error flag set keeps the full data length for its size. Every one of its data nibbles is 0.
- R8: `rsp_ready` is 0 from the cycle after acceptance until the last nibble has been sent. A response is accepted on a clock edge where `rsp_valid` and `rsp_ready` are both 1, and its first nibble appears in the next cycle. While `rsp_ready` is 0, `rsp_valid` has no effect.
- R9: Whenever `rsp_ready` is 1, the bus is idle: `tx_nib` is 0 and `tx_frame` is 0. At least one idle cycle follows every packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | A response is offered |
| rsp_ready | output | 1 | The block can take a response |
| rsp_opcode | input | 3 | Response opcode (1 means data follows) |
| rsp_size | input | 2 | Size code: 1, 2, 4 or 8 data bytes |
| rsp_error | input | 1 | Error flag |
| rsp_txn_id | input | 8 | Transaction ID to echo |
| rsp_data | input | 64 | Read data, byte 0 in bits 7:0 |
| tx_nib | output | 4 | Nibble bus |
| tx_frame | output | 1 | First-nibble-of-packet strobe |

## Verification
The bound checker holds several rules on every cycle:
- the strobe lasts exactly one cycle;
- the first nibble has bit 3 set, and the second nibble has bit 3 clear;
- the bus is idle whenever the block is ready;
- an accepted response always produces a strobe on the next cycle;
- each busy stretch lasts one of the five legal packet lengths.

Only the bench scenarios can show that the nibbles carry the right values. This covers the opcode, size and error bits of the header, the echoed ID, the data order for each size, the zeroed data of an error response, and that data and handshake attempts are ignored where they must be.

// File: rtl/bl_rsp_pkg.sv
package bl_rsp_pkg;

    localparam int NIB_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int ID_W      = 8;
    localparam int OPC_W     = 3;
    localparam int SIZE_W    = 2;
    localparam int HDR_BYTES = 2;
    localparam int MAX_BYTES = 1 << ((1 << SIZE_W) - 1);
    localparam int DATA_W    = MAX_BYTES * BYTE_W;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;
    localparam int STREAM_W  = HDR_W + DATA_W;
    localparam int MAX_NIBS  = STREAM_W / NIB_W;
    localparam int CNT_W     = $clog2(MAX_NIBS + 1);

    localparam logic [OPC_W-1:0] OPC_WITH_DATA = 3'd1;

    typedef struct packed {
        logic                busy;
        logic [CNT_W-1:0]    idx;
        logic [CNT_W-1:0]    total;
        logic [STREAM_W-1:0] stream;
        logic [NIB_W-1:0]    nib;
        logic                frame;
    } tx_state_t;

endpackage

// File: rtl/bl_rsp_hdr.sv
module bl_rsp_hdr
    import bl_rsp_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [SIZE_W-1:0] size,
    input  logic              error,
    input  logic [ID_W-1:0]   txn_id,
    output logic [HDR_W-1:0]  hdr,
    output logic              has_data,
    output logic [CNT_W-1:0]  total_nibs
);

    localparam logic [CNT_W-1:0] HDR_NIBS = CNT_W'(HDR_W / NIB_W);
    localparam logic [CNT_W-1:0] NIBS_PER_BYTE = CNT_W'(BYTE_W / NIB_W);

    always_comb begin
        // byte 0 in bits 7:0, echoed ID in bits 15:8
        hdr        = {txn_id, 1'b0, error, size, 1'b1, opcode};
        has_data   = (opcode == OPC_WITH_DATA);
        total_nibs = HDR_NIBS;
        if (has_data) begin
            total_nibs = HDR_NIBS + (NIBS_PER_BYTE << size);
        end
    end

endmodule

// File: rtl/bl_rsp_payload.sv
module bl_rsp_payload
    import bl_rsp_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [SIZE_W-1:0] size,
    input  logic              error,
    input  logic              has_data,
    output logic [DATA_W-1:0] payload
);

    localparam int NB_W = $clog2(MAX_BYTES + 1);

    logic [NB_W-1:0] n_bytes;
    assign n_bytes = NB_W'(1) << size;

    // keep only bytes inside the size window; errors carry zeros
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        logic keep;
        assign keep = has_data && !error && (NB_W'(b) < n_bytes);
        assign payload[b*BYTE_W +: BYTE_W] = keep ? data[b*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/bl_rsp_nibsel.sv
module bl_rsp_nibsel
    import bl_rsp_pkg::*;
(
    input  logic [STREAM_W-1:0] stream,
    input  logic [CNT_W-1:0]    idx,
    output logic [NIB_W-1:0]    nib
);

    logic [NIB_W-1:0] nibs [MAX_NIBS];

    for (genvar i = 0; i < MAX_NIBS; i++) begin : g_split
        assign nibs[i] = stream[i*NIB_W +: NIB_W];
    end

    always_comb begin
        nib = '0;
        for (int i = 0; i < MAX_NIBS; i++) begin
            if (idx == CNT_W'(i)) nib = nibs[i];
        end
    end

endmodule

// File: rtl/bl_rsp_tx.sv
module bl_rsp_tx
    import bl_rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [2:0]        rsp_opcode,
    input  logic [1:0]        rsp_size,
    input  logic              rsp_error,
    input  logic [7:0]        rsp_txn_id,
    input  logic [63:0]       rsp_data,
    output logic [3:0]        tx_nib,
    output logic              tx_frame
);

    tx_state_t state_d, state_q;

    logic [HDR_W-1:0]  new_hdr;
    logic              new_has_data;
    logic [CNT_W-1:0]  new_total;
    logic [DATA_W-1:0] new_payload;
    logic [NIB_W-1:0]  cur_nib;

    bl_rsp_hdr u_hdr (
        .opcode     (rsp_opcode),
        .size       (rsp_size),
        .error      (rsp_error),
        .txn_id     (rsp_txn_id),
        .hdr        (new_hdr),
        .has_data   (new_has_data),
        .total_nibs (new_total)
    );

    bl_rsp_payload u_payload (
        .data     (rsp_data),
        .size     (rsp_size),
        .error    (rsp_error),
        .has_data (new_has_data),
        .payload  (new_payload)
    );

    bl_rsp_nibsel u_nibsel (
        .stream (state_q.stream),
        .idx    (state_q.idx),
        .nib    (cur_nib)
    );

    always_comb begin
        state_d       = state_q;
        state_d.frame = 1'b0;
        if (!state_q.busy) begin
            state_d.nib = '0;
            if (rsp_valid) begin
                state_d.busy   = 1'b1;
                state_d.stream = {new_payload, new_hdr};
                state_d.total  = new_total;
                state_d.idx    = CNT_W'(1);
                state_d.nib    = new_hdr[NIB_W-1:0];
                state_d.frame  = 1'b1;
            end
        end else if (state_q.idx == state_q.total) begin
            state_d.busy = 1'b0;
            state_d.idx  = '0;
            state_d.nib  = '0;
        end else begin
            state_d.nib = cur_nib;
            state_d.idx = state_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_ready = !state_q.busy;
    assign tx_nib    = state_q.nib;
    assign tx_frame  = state_q.frame;

endmodule

// File: rtl/bl_rsp_tx_chk.sv
module bl_rsp_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [3:0] tx_nib,
    input logic       tx_frame
);

    logic [4:0] busy_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || rsp_ready) busy_cnt_q <= '0;
        else if (busy_cnt_q != 5'd31) busy_cnt_q <= busy_cnt_q + 5'd1;
    end

    assert_idle_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (tx_nib == 4'd0 && !tx_frame));

    assert_frame_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame |=> !tx_frame);

    assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (tx_frame && !rsp_ready));

    assert_hdr_bit3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame |-> tx_nib[3]);

    assert_hdr_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame |=> !tx_nib[3]);

    // covers R5 and R6: every packet has one of the legal lengths
    assert_pkt_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && busy_cnt_q != 5'd0) |->
        (busy_cnt_q == 5'd4 || busy_cnt_q == 5'd6 || busy_cnt_q == 5'd8 ||
         busy_cnt_q == 5'd12 || busy_cnt_q == 5'd20));

endmodule

bind bl_rsp_tx bl_rsp_tx_chk u_chk (.*);

// File: tb/bl_rsp_tx_tb.sv
`timescale 1ns/1ps
module bl_rsp_tx_tb;

    typedef struct {
        logic [3:0] nib;
        logic       frame;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [2:0]  rsp_opcode = '0;
    logic [1:0]  rsp_size = '0;
    logic        rsp_error = 1'b0;
    logic [7:0]  rsp_txn_id = '0;
    logic [63:0] rsp_data = '0;
    logic [3:0]  tx_nib;
    logic        tx_frame;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    bl_rsp_tx u_dut (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_opcode(rsp_opcode), .rsp_size(rsp_size), .rsp_error(rsp_error),
        .rsp_txn_id(rsp_txn_id), .rsp_data(rsp_data),
        .tx_nib(tx_nib), .tx_frame(tx_frame)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(logic [3:0] nib, logic frame, string tag);
        exp_t e;
        e.nib = nib; e.frame = frame; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send(logic [2:0] op, logic [1:0] sz, logic err,
                        logic [7:0] id, logic [63:0] data);
        logic [7:0] b0;
        b0 = {1'b0, err, sz, 1'b1, op};
        push(b0[3:0], 1'b1, "R2");
        push(b0[7:4], 1'b0, "R2");
        push(id[3:0], 1'b0, "R3");
        push(id[7:4], 1'b0, "R3");
        if (op == 3'd1) begin
            for (int b = 0; b < (1 << sz); b++) begin
                logic [7:0] v;
                v = err ? 8'h00 : data[b*8 +: 8];
                push(v[3:0], 1'b0, err ? "R7" : "R5");
                push(v[7:4], 1'b0, err ? "R7" : "R5");
            end
        end
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        rsp_valid = 1'b1; rsp_opcode = op; rsp_size = sz;
        rsp_error = err; rsp_txn_id = id; rsp_data = data;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (!rsp_ready || sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops one expected item per busy cycle, checks idle otherwise
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (!rsp_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6", "unexpected nibble", tx_nib, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(tx_nib == e.nib, e.tag, "nibble", tx_nib, e.nib);
                        check(tx_frame == e.frame, e.frame ? "R4" : e.tag, "frame",
                              tx_frame, e.frame);
                    end
                end else begin
                    check(tx_nib == 4'd0 && !tx_frame, "R9", "idle bus",
                          {tx_frame, tx_nib}, 0);
                    check(sb.size() == 0 || sb[0].frame, "R8", "pending item while ready",
                          sb.size(), 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_ready == 1'b1, "R1", "ready in reset", rsp_ready, 1);
        check(tx_nib == 4'd0 && !tx_frame, "R1", "bus in reset", {tx_frame, tx_nib}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_ready == 1'b1, "R1", "ready after reset", rsp_ready, 1);
        check(tx_nib == 4'd0 && !tx_frame, "R1", "bus after reset", {tx_frame, tx_nib}, 0);
        mon_en = 1'b1;

        // R5: every size with data
        send(3'd1, 2'd0, 1'b0, 8'hA5, 64'h0123_4567_89AB_CDEF);
        send(3'd1, 2'd1, 1'b0, 8'h3C, 64'hFFFF_FFFF_FFFF_B7E2);
        send(3'd1, 2'd2, 1'b0, 8'h00, 64'h1111_1111_DEAD_BEEF);
        send(3'd1, 2'd3, 1'b0, 8'hFF, 64'h8877_6655_4433_2211);
        drain();
        // R6: plain acknowledgements ignore data
        send(3'd0, 2'd3, 1'b0, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF);
        send(3'd6, 2'd2, 1'b1, 8'h81, 64'h1234_5678_9ABC_DEF0);
        send(3'd0, 2'd0, 1'b1, 8'h7E, 64'h0);
        drain();
        // R7: error with data keeps length, zero data
        send(3'd1, 2'd3, 1'b1, 8'hC3, 64'hFFFF_FFFF_FFFF_FFFF);
        send(3'd1, 2'd1, 1'b1, 8'h19, 64'hABCD_ABCD_ABCD_ABCD);
        drain();
        // R8: valid while busy is ignored
        send(3'd1, 2'd3, 1'b0, 8'h42, 64'hFEDC_BA98_7654_3210);
        rsp_valid = 1'b1; rsp_opcode = 3'd1; rsp_size = 2'd0;
        rsp_txn_id = 8'hEE; rsp_data = 64'h99;
        repeat (6) @(negedge clk);
        check(rsp_ready == 1'b0, "R8", "ready while busy", rsp_ready, 0);
        rsp_valid = 1'b0;
        drain();
        check(sb.size() == 0, "R8", "scoreboard empty", sb.size(), 0);
        check(rsp_ready == 1'b1 && tx_nib == 4'd0, "R9", "idle after traffic",
              {rsp_ready, tx_nib}, 16);

        mon_en = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule